// File: doc/BRIEF.md
# Maskable Alarm Interrupt Unit

This block watches a time-of-day value (seconds, minutes, hours, day of week, all as BCD bytes) and compares it against two independent alarm register sets. Each alarm set holds four byte registers. The top bit of each register masks that field out of the comparison. Masking lets one alarm repeat at any rate from every second up to once a week. The comparison runs only on the cycle in which the external time counter raises its tick strobe. At that point the time is already up to date, so one matching second sets the alarm's request flag once.

The two request flags appear in a status byte and drive two active-low interrupt outputs. A routing bit selects the output arrangement. In one setting each alarm has its own output. In the other, both alarms share the first output and the second output stays inactive. Each alarm also has its own enable bit that gates its interrupt. Any read or write of one of an alarm's registers clears that alarm's flag as a side effect. A host therefore acknowledges an alarm simply by touching its registers.

The timekeeping counter and the serial host link sit outside this block. Both connect through the time inputs, the tick strobe and the register access strobes.

Top module: `alarm_irq_unit`

## Requirements
- R1: Each alarm (select 0 or 1) has four 8-bit registers chosen by a 2-bit field code: 0 seconds, 1 minutes, 2 hours, 3 day. A write stores the data on the clock edge. The read data shows the selected register in the same cycle. All registers are 0 after reset.
- R2: Bit 7 of an alarm register masks its field. An unmasked field matches only when bits 6:0 of the register equal bits 6:0 of the corresponding time input. A masked field always matches.
- R3: With bit 7 set in all four registers of an alarm, every tick sets that alarm's flag.
- R4: With no mask bit set, the flag is set only when seconds, minutes, hours and day all match.
- R5: Matching is evaluated only on cycles with tick high. A flag becomes visible on the cycle after that edge and stays set until cleared. A matching time without a tick sets nothing.
- R6: A read or write of any register of one alarm clears that alarm's flag on the next edge and leaves the other flag unchanged. If the same edge also carries a match for that alarm, the flag is set.
- R7: With the routing bit at 1, the first interrupt output is low exactly while flag 0 and enable 0 are both 1. The second interrupt output is low exactly while flag 1 and enable 1 are both 1.
- R8: With the routing bit at 0, the first interrupt output is low while either alarm has both its flag and its enable at 1. The second interrupt output stays high.
- R9: An enable at 0 keeps its alarm from pulling any interrupt output low. The alarm's flag stays readable in the status byte.
- R10: The status byte carries flag 0 in bit 0 and flag 1 in bit 1. All other bits are 0.
- R11: The hours register is compared with the full 12/24-hour encoding of the time hours byte. This includes the mode bit (6) and the PM bit (5), so 11 PM in 12-hour form (0x71) does not match 11 AM (0x51).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-updated strobe; matching happens on this cycle |
| tm_sec | input | 8 | Current seconds (BCD) |
| tm_min | input | 8 | Current minutes (BCD) |
| tm_hour | input | 8 | Current hours (BCD, 12/24-hour encoding) |
| tm_day | input | 8 | Current day of week |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_alarm | input | 1 | Alarm set select for access |
| acc_field | input | 2 | Register select inside the set (0 sec, 1 min, 2 hour, 3 day) |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data of the selected register |
| ctl_sep | input | 1 | Routing bit: 1 separate outputs, 0 shared first output |
| ctl_en0 | input | 1 | Interrupt enable for alarm 0 |
| ctl_en1 | input | 1 | Interrupt enable for alarm 1 |
| stat_out | output | 8 | Status byte with the two request flags |
| irq0_n | output | 1 | First interrupt output, active low |
| irq1_n | output | 1 | Second interrupt output, active low |

## Verification
A tick or a register access changes the flags on the rising edge where it is applied. The status byte therefore reflects it one cycle later. Read data and both interrupt outputs follow the stored state and the control inputs with no further register stage. The bench applies every stimulus on a falling edge and advances its behavioural model on the next rising edge. It then compares status, read data and both interrupt pins on the falling edge that follows. Every result is checked in exactly the cycle it is due.

// File: rtl/alarm_irq_pkg.sv
// Package: shared constants and types of the alarm interrupt unit.
// Assumes exactly two alarm sets, each of four byte-wide fields.
package alarm_irq_pkg;
    localparam int NUM_ALARMS = 2;
    localparam int NFIELD     = 4;
    localparam int FSEL_W     = $clog2(NFIELD);
    localparam int ASEL_W     = $clog2(NUM_ALARMS);

    // Field codes used by the register select; order matches the time vector.
    typedef enum logic [FSEL_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DAY  = 2'd3
    } field_e;
endpackage

// File: rtl/alarm_regset.sv
// Module: alarm_regset
// Holds the four alarm registers of one alarm set and returns the selected one.
// Assumes the caller qualifies wr_en with the alarm select.
module alarm_regset
    import alarm_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [FSEL_W-1:0]              field,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NFIELD-1:0][DATA_W-1:0]  regs,
    output logic [DATA_W-1:0]              rdata
);
    logic [NFIELD-1:0][DATA_W-1:0] regs_q;

    // Store a written byte into the addressed field register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en) begin
            regs_q[field] <= wdata;
        end
    end

    // Expose the register contents and the selected byte.
    always_comb begin
        regs  = regs_q;
        rdata = regs_q[field];
    end
endmodule

// File: rtl/alarm_match.sv
// Module: alarm_match
// Compares one alarm set with the current time; the top bit of each register masks its field.
// Assumes time and alarm bytes use the same encoding in bits below the mask bit.
module alarm_match
    import alarm_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NFIELD-1:0][DATA_W-1:0] regs,
    input  logic [NFIELD-1:0][DATA_W-1:0] tm,
    output logic                          hit
);
    localparam int MSK = DATA_W - 1;

    logic [NFIELD-1:0] fld_ok;

    for (genvar f = 0; f < NFIELD; f++) begin : g_fld
        // A field agrees when masked or when its value bits are equal.
        assign fld_ok[f] = regs[f][MSK] || (regs[f][MSK-1:0] == tm[f][MSK-1:0]);
    end

    // The alarm matches only when every field agrees.
    assign hit = &fld_ok;
endmodule

// File: rtl/alarm_flag.sv
// Module: alarm_flag
// Sticky request flag: set by a qualified match, cleared by an access to its alarm set.
// Assumes set has priority so a match coinciding with an access is not lost.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Update the flag with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_route.sv
// Module: irq_route
// Gates the two flags with their enables and steers them to two active-low outputs.
// Assumes sep=1 gives one output per alarm, sep=0 merges both on the first output.
module irq_route
    import alarm_irq_pkg::*;
(
    input  logic [NUM_ALARMS-1:0] flags,
    input  logic [NUM_ALARMS-1:0] en,
    input  logic                  sep,
    output logic                  irq0_n,
    output logic                  irq1_n
);
    logic [NUM_ALARMS-1:0] req;

    // Qualify each flag with its enable.
    assign req = flags & en;

    // Select the output arrangement.
    always_comb begin
        if (sep) begin
            irq0_n = ~req[0];
            irq1_n = ~req[1];
        end else begin
            irq0_n = ~(|req);
            irq1_n = 1'b1;
        end
    end
endmodule

// File: rtl/alarm_irq_unit.sv
// Module: alarm_irq_unit (top)
// Two maskable time-of-day alarms with sticky request flags and routed interrupts.
// Assumes tick marks the cycle in which the time inputs hold the newly updated time,
// and that register accesses are single-cycle strobes from the host side.
module alarm_irq_unit
    import alarm_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] tm_sec,
    input  logic [DATA_W-1:0] tm_min,
    input  logic [DATA_W-1:0] tm_hour,
    input  logic [DATA_W-1:0] tm_day,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [ASEL_W-1:0] acc_alarm,
    input  logic [FSEL_W-1:0] acc_field,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              ctl_sep,
    input  logic              ctl_en0,
    input  logic              ctl_en1,
    output logic [DATA_W-1:0] stat_out,
    output logic              irq0_n,
    output logic              irq1_n
);
    logic [NFIELD-1:0][DATA_W-1:0] tm_vec;
    logic [NUM_ALARMS-1:0]         flags;
    logic [DATA_W-1:0]             rd_arr [NUM_ALARMS];

    // Gather the time fields in field-code order.
    assign tm_vec = {tm_day, tm_hour, tm_min, tm_sec};

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        logic                          sel;
        logic                          hit;
        logic [NFIELD-1:0][DATA_W-1:0] regs;

        // Decode whether the current access targets this alarm set.
        assign sel = (acc_alarm == ASEL_W'(a));

        alarm_regset #(.DATA_W(DATA_W)) u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (acc_wr && sel),
            .field (acc_field),
            .wdata (acc_wdata),
            .regs  (regs),
            .rdata (rd_arr[a])
        );

        alarm_match #(.DATA_W(DATA_W)) u_match (
            .regs (regs),
            .tm   (tm_vec),
            .hit  (hit)
        );

        alarm_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (tick && hit),
            .clr_i  (sel && (acc_wr || acc_rd)),
            .flag_o (flags[a])
        );
    end

    // Return the selected register of the selected alarm.
    assign acc_rdata = rd_arr[acc_alarm];

    // Place the flags in the low status bits, pad the rest with zero.
    assign stat_out = DATA_W'(flags);

    irq_route u_route (
        .flags  (flags),
        .en     ({ctl_en1, ctl_en0}),
        .sep    (ctl_sep),
        .irq0_n (irq0_n),
        .irq1_n (irq1_n)
    );
endmodule

// File: rtl/alarm_irq_unit_chk.sv
// Module: alarm_irq_unit_chk
// Port-level temporal checks for alarm_irq_unit, attached by bind below.
// Assumes the one-bit alarm select of the default configuration.
module alarm_irq_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              acc_wr,
    input logic              acc_rd,
    input logic              acc_alarm,
    input logic              ctl_sep,
    input logic              ctl_en0,
    input logic              ctl_en1,
    input logic [DATA_W-1:0] stat_out,
    input logic              irq0_n,
    input logic              irq1_n
);
    // A flag can only rise on the cycle after a tick.
    p_rise_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_out[0]) |-> $past(tick));

    // Without tick or access to alarm 0, flag 0 holds its value.
    p_hold_flag0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(!acc_alarm && (acc_wr || acc_rd))) |=> $stable(stat_out[0]));

    // An access to alarm 0 without a tick leaves flag 0 clear.
    p_clear_flag0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !acc_alarm && (acc_wr || acc_rd)) |=> !stat_out[0]);

    // An access to alarm 1 without a tick leaves flag 1 clear.
    p_clear_flag1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && acc_alarm && (acc_wr || acc_rd)) |=> !stat_out[1]);

    // An active first output needs at least one flag.
    p_irq0_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq0_n |-> (stat_out[1:0] != 2'b00));

    // In shared routing the second output stays inactive.
    p_irq1_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_sep |-> irq1_n);

    // With both enables off no output is active.
    p_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en0 && !ctl_en1) |-> (irq0_n && irq1_n));

    // Status bits above the two flags read zero.
    p_status_pad_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_out[DATA_W-1:2] == '0);
endmodule

bind alarm_irq_unit alarm_irq_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_alarm (acc_alarm),
    .ctl_sep   (ctl_sep),
    .ctl_en0   (ctl_en0),
    .ctl_en1   (ctl_en1),
    .stat_out  (stat_out),
    .irq0_n    (irq0_n),
    .irq1_n    (irq1_n)
);

// File: tb/alarm_irq_unit_test.sv
// Bench for alarm_irq_unit: behavioural reference model compared on every clock,
// plus directed checks per requirement.
module alarm_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] tm_sec = 8'h00, tm_min = 8'h00, tm_hour = 8'h00, tm_day = 8'h00;
    logic       acc_wr = 1'b0, acc_rd = 1'b0, acc_alarm = 1'b0;
    logic [1:0] acc_field = 2'd0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic       ctl_sep = 1'b1, ctl_en0 = 1'b0, ctl_en1 = 1'b0;
    logic [7:0] stat_out;
    logic       irq0_n, irq1_n;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;

    logic [7:0] m_reg [2][4];
    bit         m_flag [2];

    always #4 clk = ~clk;

    alarm_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_day(tm_day),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_alarm(acc_alarm),
        .acc_field(acc_field), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .ctl_sep(ctl_sep), .ctl_en0(ctl_en0), .ctl_en1(ctl_en1),
        .stat_out(stat_out), .irq0_n(irq0_n), .irq1_n(irq1_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit model_hit(input int a);
        logic [7:0] t [4];
        bit ok = 1;
        t[0] = tm_sec; t[1] = tm_min; t[2] = tm_hour; t[3] = tm_day;
        for (int f = 0; f < 4; f++)
            if (!m_reg[a][f][7] && (m_reg[a][f][6:0] != t[f][6:0])) ok = 0;
        return ok;
    endfunction

    task automatic model_step();
        bit hit [2];
        if (!rst_n) begin
            for (int a = 0; a < 2; a++) begin
                m_flag[a] = 0;
                for (int f = 0; f < 4; f++) m_reg[a][f] = 8'h00;
            end
            return;
        end
        for (int a = 0; a < 2; a++) hit[a] = model_hit(a);
        for (int a = 0; a < 2; a++) begin
            bit touched = (acc_wr || acc_rd) && (int'(acc_alarm) == a);
            if (acc_wr && int'(acc_alarm) == a) m_reg[a][acc_field] = acc_wdata;
            if (tick && hit[a]) m_flag[a] = 1;
            else if (touched) m_flag[a] = 0;
        end
    endtask

    task automatic compare_all();
        bit r0 = m_flag[0] && ctl_en0;
        bit r1 = m_flag[1] && ctl_en1;
        logic e0, e1;
        if (ctl_sep) begin e0 = !r0; e1 = !r1; end
        else begin e0 = !(r0 || r1); e1 = 1'b1; end
        chk("R10 status byte", stat_out, {6'b0, m_flag[1], m_flag[0]});
        chk("R1 read data", acc_rdata, m_reg[acc_alarm][acc_field]);
        chk(ctl_sep ? "R7 irq0_n" : "R8 irq0_n", {7'b0, irq0_n}, {7'b0, e0});
        chk(ctl_sep ? "R7 irq1_n" : "R8 irq1_n", {7'b0, irq1_n}, {7'b0, e1});
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_reg(input bit a, input int f, input logic [7:0] d);
        acc_wr = 1; acc_alarm = a; acc_field = 2'(f); acc_wdata = d;
        cycle();
        acc_wr = 0;
    endtask

    task automatic set_alarm(input bit a, input logic [7:0] s, m, h, d);
        wr_reg(a, 0, s); wr_reg(a, 1, m); wr_reg(a, 2, h); wr_reg(a, 3, d);
    endtask

    task automatic rd_reg(input bit a, input int f);
        acc_rd = 1; acc_alarm = a; acc_field = 2'(f);
        cycle();
        acc_rd = 0;
    endtask

    task automatic do_tick(input logic [7:0] s, m, h, d);
        tm_sec = s; tm_min = m; tm_hour = h; tm_day = d; tick = 1;
        cycle();
        tick = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R5: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        // Reset state
        chk("R1 reset read data", acc_rdata, 8'h00);
        chk("R10 reset status", stat_out, 8'h00);
        chk("R7 reset irq0_n", {7'b0, irq0_n}, 8'h01);

        ctl_sep = 1; ctl_en0 = 1; ctl_en1 = 1;
        // R3: all fields masked, every tick matches
        set_alarm(0, 8'h80, 8'h80, 8'h80, 8'h80);
        do_tick(8'h01, 8'h02, 8'h03, 8'h04);
        chk("R3 every-second flag", {7'b0, stat_out[0]}, 8'h01);
        chk("R7 irq0_n low", {7'b0, irq0_n}, 8'h00);
        chk("R7 irq1_n high", {7'b0, irq1_n}, 8'h01);
        rd_reg(0, 2);
        chk("R6 read clears flag0", {7'b0, stat_out[0]}, 8'h00);
        do_tick(8'h02, 8'h02, 8'h03, 8'h04);
        chk("R3 next tick sets again", {7'b0, stat_out[0]}, 8'h01);

        // R2: only seconds compared on alarm 1
        set_alarm(1, 8'h30, 8'h80, 8'h80, 8'h80);
        do_tick(8'h29, 8'h10, 8'h05, 8'h02);
        chk("R2 seconds mismatch", {7'b0, stat_out[1]}, 8'h00);
        do_tick(8'h30, 8'h11, 8'h06, 8'h03);
        chk("R2 seconds match", {7'b0, stat_out[1]}, 8'h01);
        chk("R7 irq1_n low", {7'b0, irq1_n}, 8'h00);
        wr_reg(1, 3, 8'h80);
        chk("R6 write clears flag1", {7'b0, stat_out[1]}, 8'h00);
        chk("R6 other flag kept", {7'b0, stat_out[0]}, 8'h01);

        // R4: full match needed
        set_alarm(0, 8'h15, 8'h42, 8'h23, 8'h05);
        do_tick(8'h15, 8'h42, 8'h23, 8'h04);
        chk("R4 day differs", {7'b0, stat_out[0]}, 8'h00);
        do_tick(8'h15, 8'h42, 8'h23, 8'h05);
        chk("R4 full match", {7'b0, stat_out[0]}, 8'h01);
        do_tick(8'h16, 8'h42, 8'h23, 8'h05);
        chk("R5 flag sticky", {7'b0, stat_out[0]}, 8'h01);
        rd_reg(0, 0);
        tm_sec = 8'h15;
        cycle();
        chk("R5 no tick no set", {7'b0, stat_out[0]}, 8'h00);

        // R11: hour encoding incl. 12h and PM bits
        set_alarm(1, 8'h80, 8'h80, 8'h71, 8'h80);
        do_tick(8'h00, 8'h00, 8'h51, 8'h01);
        chk("R11 AM vs PM", {7'b0, stat_out[1]}, 8'h00);
        do_tick(8'h01, 8'h00, 8'h71, 8'h01);
        chk("R11 PM match", {7'b0, stat_out[1]}, 8'h01);
        acc_alarm = 1; acc_field = 2'd2;
        cycle();
        chk("R1 hour readback", acc_rdata, 8'h71);

        // R8: shared routing
        ctl_sep = 0;
        cycle();
        chk("R8 merged irq0_n low", {7'b0, irq0_n}, 8'h00);
        chk("R8 irq1_n idle", {7'b0, irq1_n}, 8'h01);

        // R9: enable gating
        ctl_en1 = 0;
        cycle();
        chk("R9 disabled irq0_n high", {7'b0, irq0_n}, 8'h01);
        chk("R9 flag still visible", {7'b0, stat_out[1]}, 8'h01);
        ctl_en1 = 1; ctl_sep = 1;

        // R6: match wins over simultaneous access
        set_alarm(0, 8'h80, 8'h80, 8'h80, 8'h80);
        acc_rd = 1; acc_alarm = 0; acc_field = 2'd1;
        do_tick(8'h05, 8'h05, 8'h05, 8'h05);
        acc_rd = 0;
        chk("R6 match beats clear", {7'b0, stat_out[0]}, 8'h01);
        repeat (4) cycle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule